// File: doc/BRIEF.md
# Prioritized Pending-Interrupt Selector

This block keeps one pending bit for each of fourteen interrupt sources of a processor core. Each source raises its bit with a one-cycle set pulse, and an explicit clear pulse drops it again. In every cycle where the core signals that it can accept an interrupt, the block gates the pending bits with the core's state flags. It then picks the single highest-priority eligible request and issues it as a registered take strobe. The strobe comes with an encoded identifier and a one-hot vector.

On the same clock edge that issues the strobe, the block decides whether the chosen source's pending bit is cleared. Most sources are cleared when they are taken. The hypervisor decrementer is never cleared by a take. The two external-style sources stay pending while they are configured as level-sensitive. The decrementer is cleared only when a configuration input requests clear-on-delivery. The core's ready input is a plain enable, not a handshake. When ready is low nothing is issued and the pending state only accumulates. Vector computation and the saving of core state belong elsewhere.

Top module: `irq_take_sel`

## Requirements
- R1: After reset, all pending bits are clear, `take_o` is 0, `take_id_o` is 15 and `take_hot_o` is 0.
- R2: The identifiers, listed from highest to lowest priority, are: reset 0, machine check 1, debug 2, hypervisor decrementer 3, critical external 4, watchdog 5, critical doorbell 6, fixed-interval timer 7, programmable interval timer 8, decrementer 9, external 10, doorbell 11, performance monitor 12, thermal 13. The eligible request with the lowest identifier is the one taken, and `take_hot_o` has only bit `take_id_o` set.
- R3: A take happens at a clock edge where `ready_i` is 1 and at least one request is eligible. The outputs show the take for exactly the cycle after that edge. At most one source is taken per edge, and none is taken at an edge where `ready_i` is 0.
- R4: When no take happens at an edge, the following cycle shows `take_o` 0, `take_id_o` 15 and `take_hot_o` 0.
- R5: Reset and debug requests are always eligible. A machine-check request is eligible only while `mce_i` is 1.
- R6: Critical external, watchdog and critical doorbell requests are eligible only while `ce_i` is 1.
- R7: Fixed-interval timer, programmable interval timer, decrementer, external, doorbell, performance monitor and thermal requests are eligible only while `ee_i` is 1.
- R8: A hypervisor decrementer request is eligible only when `hdice_i` is 1 and at least one of the following holds: `ee_i` is 1, `hv_i` is 0, or `pr_i` is 1. Its pending bit is kept when it is taken.
- R9: Reset, machine check, debug, watchdog, critical doorbell, fixed-interval timer, programmable interval timer, doorbell, performance monitor and thermal clear their pending bit when they are taken.
- R10: Critical external (level select `cext_level_i`) and external (level select `ext_level_i`) keep their pending bit when taken while their select is 1, and clear it while their select is 0.
- R11: A taken decrementer clears its pending bit only while `dec_clr_i` is 1.
- R12: `clr_i[k]` clears pending bit k at the next edge. A set pulse wins over both `clr_i` and a take-clear for the same bit at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_i | input | 14 | Set pulse per source, bit k = identifier k |
| clr_i | input | 14 | Clear pulse per source |
| mce_i | input | 1 | Machine-check enable flag |
| ce_i | input | 1 | Critical enable flag |
| ee_i | input | 1 | External enable flag |
| hv_i | input | 1 | Hypervisor state flag |
| pr_i | input | 1 | Problem state flag |
| hdice_i | input | 1 | Hypervisor decrementer enable |
| cext_level_i | input | 1 | Critical external is level-sensitive |
| ext_level_i | input | 1 | External is level-sensitive |
| dec_clr_i | input | 1 | Decrementer clears on delivery |
| ready_i | input | 1 | Core can take an interrupt this cycle |
| take_o | output | 1 | Registered take strobe |
| take_id_o | output | 4 | Taken identifier, 15 when none |
| take_hot_o | output | 14 | One-hot form of the taken identifier |

## Verification
A set pulse becomes pending at the edge that ends its cycle, so it can first be taken one edge later. A take driven in a cycle appears on the outputs right after the edge that ends that cycle. The bench drives every cycle at the falling edge and queues one expected result for it. A monitor pops that result one nanosecond after the next rising edge, so each check lands on the cycle it belongs to. Whether a pending bit was kept or cleared is seen in the cycle that follows, as a repeated take or as the none code.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int NUM_SRC = 14;
  localparam int ID_W    = $clog2(NUM_SRC + 1);
  localparam logic [ID_W-1:0] ID_NONE = '1;

  localparam int SRC_RST  = 0;
  localparam int SRC_MCHK = 1;
  localparam int SRC_DBG  = 2;
  localparam int SRC_HDEC = 3;
  localparam int SRC_CEXT = 4;
  localparam int SRC_WDT  = 5;
  localparam int SRC_CDB  = 6;
  localparam int SRC_FIT  = 7;
  localparam int SRC_PIT  = 8;
  localparam int SRC_DEC  = 9;
  localparam int SRC_EXT  = 10;
  localparam int SRC_DB   = 11;
  localparam int SRC_PERF = 12;
  localparam int SRC_THRM = 13;

  typedef enum logic [2:0] {
    GATE_FREE, GATE_MCE, GATE_CE, GATE_EE, GATE_HDEC
  } gate_e;

  typedef enum logic [2:0] {
    CLR_ALWAYS, CLR_KEEP, CLR_CEXT_LVL, CLR_EXT_LVL, CLR_DEC_CFG
  } clr_e;

  function automatic gate_e gate_of(int idx);
    case (idx)
      SRC_RST, SRC_DBG:           return GATE_FREE;
      SRC_MCHK:                   return GATE_MCE;
      SRC_HDEC:                   return GATE_HDEC;
      SRC_CEXT, SRC_WDT, SRC_CDB: return GATE_CE;
      default:                    return GATE_EE;
    endcase
  endfunction

  function automatic clr_e clr_of(int idx);
    case (idx)
      SRC_HDEC: return CLR_KEEP;
      SRC_CEXT: return CLR_CEXT_LVL;
      SRC_EXT:  return CLR_EXT_LVL;
      SRC_DEC:  return CLR_DEC_CFG;
      default:  return CLR_ALWAYS;
    endcase
  endfunction
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int N = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] take_clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign pend_d[i] = (pend_q[i] & ~(clr_i[i] | take_clr_i[i])) | set_i[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R12: a set pulse always lands in the pending register
  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_sel_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend_i,
  input  logic         mce_i,
  input  logic         ce_i,
  input  logic         ee_i,
  input  logic         hv_i,
  input  logic         pr_i,
  input  logic         hdice_i,
  output logic [N-1:0] elig_o
);
  logic hdec_ok;
  assign hdec_ok = hdice_i & (ee_i | ~hv_i | pr_i);

  for (genvar i = 0; i < N; i++) begin : g_src
    localparam gate_e G = gate_of(i);
    if (G == GATE_FREE) begin : g_free
      assign elig_o[i] = pend_i[i];
    end else if (G == GATE_MCE) begin : g_mce
      assign elig_o[i] = pend_i[i] & mce_i;
    end else if (G == GATE_CE) begin : g_ce
      assign elig_o[i] = pend_i[i] & ce_i;
    end else if (G == GATE_HDEC) begin : g_hdec
      assign elig_o[i] = pend_i[i] & hdec_ok;
    end else begin : g_ee
      assign elig_o[i] = pend_i[i] & ee_i;
    end
  end

  // R5: machine check never eligible with its enable low
  p_mce_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    elig_o[SRC_MCHK] |-> mce_i);
  // R7: thermal never eligible with external enable low
  p_ee_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    elig_o[SRC_THRM] |-> ee_i);
  // R8: hypervisor decrementer needs its enable bit
  p_hdec_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    elig_o[SRC_HDEC] |-> hdice_i);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N    = 14,
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    elig_i,
  output logic [N-1:0]    grant_o,
  output logic [ID_W-1:0] id_o,
  output logic            any_o
);
  always_comb begin
    grant_o = '0;
    id_o    = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        grant_o = '0;
        grant_o[i] = 1'b1;
        id_o = ID_W'(i);
      end
    end
  end

  assign any_o = |elig_i;

  // R2: a single grant, and nothing eligible above it
  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && (any_o == (grant_o != '0)));
  p_grant_highest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> ((elig_i & (grant_o - N'(1))) == '0));
endmodule

// File: rtl/irq_take_sel.sv
module irq_take_sel
  import irq_sel_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               mce_i,
  input  logic               ce_i,
  input  logic               ee_i,
  input  logic               hv_i,
  input  logic               pr_i,
  input  logic               hdice_i,
  input  logic               cext_level_i,
  input  logic               ext_level_i,
  input  logic               dec_clr_i,
  input  logic               ready_i,
  output logic               take_o,
  output logic [ID_W-1:0]    take_id_o,
  output logic [NUM_SRC-1:0] take_hot_o
);
  logic [NUM_SRC-1:0] pend, elig, grant, clr_pol, take_clr;
  logic [ID_W-1:0]    pick_id;
  logic               any, take;

  irq_pend_reg #(.N(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(set_i), .clr_i(clr_i),
    .take_clr_i(take_clr), .pend_o(pend)
  );

  irq_gate #(.N(NUM_SRC)) u_gate (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .mce_i(mce_i), .ce_i(ce_i),
    .ee_i(ee_i), .hv_i(hv_i), .pr_i(pr_i), .hdice_i(hdice_i), .elig_o(elig)
  );

  irq_prio_pick #(.N(NUM_SRC), .ID_W(ID_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .elig_i(elig), .grant_o(grant),
    .id_o(pick_id), .any_o(any)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pol
    localparam clr_e C = clr_of(i);
    if (C == CLR_ALWAYS) begin : g_always
      assign clr_pol[i] = 1'b1;
    end else if (C == CLR_KEEP) begin : g_keep
      assign clr_pol[i] = 1'b0;
    end else if (C == CLR_CEXT_LVL) begin : g_cext
      assign clr_pol[i] = ~cext_level_i;
    end else if (C == CLR_EXT_LVL) begin : g_ext
      assign clr_pol[i] = ~ext_level_i;
    end else begin : g_dec
      assign clr_pol[i] = dec_clr_i;
    end
  end

  assign take     = ready_i & any;
  assign take_clr = take ? (grant & clr_pol) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_o     <= 1'b0;
      take_id_o  <= ID_NONE;
      take_hot_o <= '0;
    end else if (take) begin
      take_o     <= 1'b1;
      take_id_o  <= pick_id;
      take_hot_o <= grant;
    end else begin
      take_o     <= 1'b0;
      take_id_o  <= ID_NONE;
      take_hot_o <= '0;
    end
  end

  // R3: no strobe after an edge without ready
  p_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |=> !take_o);
  // R4: idle outputs carry the none code
  p_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (take_id_o == ID_NONE && take_hot_o == '0));
  // R2: a strobe carries exactly one hot bit
  p_hot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ($countones(take_hot_o) == 1));
  // R8: taken hypervisor decrementer stays pending
  p_hd_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && take_id_o == ID_W'(SRC_HDEC) && !$past(clr_i[SRC_HDEC]))
      |-> pend[SRC_HDEC]);
endmodule

// File: tb/test_irq_take_sel.sv
`timescale 1ns/1ps
module test_irq_take_sel;
  localparam int N = 14;
  localparam int NONE = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] set_s = '0, clr_s = '0;
  logic mce = 1, ce = 1, ee = 1, hv = 0, pr = 0, hdice = 0;
  logic cext_lvl = 0, ext_lvl = 0, dec_clr = 1, ready = 0;
  logic take;
  logic [3:0] take_id;
  logic [N-1:0] take_hot;

  int n_checks = 0, n_fail = 0;
  int q_id[$];
  string q_tag[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_take_sel i_irq_take_sel (
    .clk(clk), .rst_n(rst_n), .set_i(set_s), .clr_i(clr_s),
    .mce_i(mce), .ce_i(ce), .ee_i(ee), .hv_i(hv), .pr_i(pr),
    .hdice_i(hdice), .cext_level_i(cext_lvl), .ext_level_i(ext_lvl),
    .dec_clr_i(dec_clr), .ready_i(ready),
    .take_o(take), .take_id_o(take_id), .take_hot_o(take_hot)
  );

  function automatic logic [N-1:0] b(int k);
    logic [N-1:0] v = '0;
    v[k] = 1'b1;
    return v;
  endfunction

  // driver: one cycle of stimulus, one expected result
  task automatic cyc(input logic [N-1:0] s, input logic [N-1:0] c,
                     input logic rdy, input int exp_id, input string tag);
    @(negedge clk);
    set_s = s; clr_s = c; ready = rdy;
    q_id.push_back(exp_id);
    q_tag.push_back(tag);
    @(posedge clk);
    #1;
  endtask

  // monitor: scoreboard compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_id.size() > 0) begin
        int e;
        string t;
        logic [N-1:0] eh;
        e = q_id.pop_front();
        t = q_tag.pop_front();
        eh = (e == NONE) ? '0 : b(e);
        n_checks++;
        if (take !== (e != NONE) || take_id !== 4'(e) || take_hot !== eh) begin
          n_fail++;
          $display("FAIL %s: take=%0d id=%0d hot=%h expected take=%0d id=%0d hot=%h",
                   t, take, take_id, take_hot, (e != NONE), e, eh);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R3: watchdog expired, actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int order[13] = '{0, 1, 2, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R4 nothing pending
    cyc('0, '0, 0, NONE, "R1");
    cyc('0, '0, 1, NONE, "R4");
    // R2 full priority walk, R9 clear on take (hdec disabled)
    cyc('1, '0, 0, NONE, "R3");
    foreach (order[k]) cyc('0, '0, 1, order[k], "R2");
    cyc('0, '0, 1, NONE, "R9");
    // R8 hypervisor decrementer stays pending
    hdice = 1;
    cyc('0, '0, 1, 3, "R8");
    cyc('0, '0, 1, 3, "R8");
    cyc('0, b(3), 0, NONE, "R12");
    cyc('0, '0, 1, NONE, "R12");
    // R3 waits for ready
    cyc(b(10), '0, 0, NONE, "R3");
    cyc('0, '0, 0, NONE, "R3");
    cyc('0, '0, 1, 10, "R3");
    cyc('0, '0, 1, NONE, "R10");
    // R5 gating
    mce = 0;
    cyc(b(1), '0, 0, NONE, "R5");
    cyc('0, '0, 1, NONE, "R5");
    mce = 1;
    cyc('0, '0, 1, 1, "R5");
    mce = 0; ce = 0; ee = 0;
    cyc(b(0) | b(2), '0, 0, NONE, "R5");
    cyc('0, '0, 1, 0, "R5");
    cyc('0, '0, 1, 2, "R5");
    cyc('0, '0, 1, NONE, "R5");
    mce = 1; ce = 1; ee = 1;
    // R6 critical gating
    ce = 0;
    cyc(b(4) | b(5) | b(7), '0, 0, NONE, "R6");
    cyc('0, '0, 1, 7, "R6");
    cyc('0, '0, 1, NONE, "R6");
    ce = 1;
    cyc('0, '0, 1, 4, "R6");
    cyc('0, '0, 1, 5, "R6");
    cyc('0, '0, 1, NONE, "R6");
    // R7 external gating
    ee = 0;
    cyc(b(9) | b(13), '0, 0, NONE, "R7");
    cyc('0, '0, 1, NONE, "R7");
    ee = 1;
    cyc('0, '0, 1, 9, "R7");
    cyc('0, '0, 1, 13, "R7");
    cyc('0, '0, 1, NONE, "R7");
    // R8 gating combinations
    ee = 0; hv = 1; pr = 0;
    cyc(b(3), '0, 0, NONE, "R8");
    cyc('0, '0, 1, NONE, "R8");
    pr = 1;
    cyc('0, '0, 1, 3, "R8");
    pr = 0; hv = 0;
    cyc('0, '0, 1, 3, "R8");
    hv = 1; ee = 1;
    cyc('0, '0, 1, 3, "R8");
    hdice = 0;
    cyc('0, '0, 1, NONE, "R8");
    cyc('0, b(3), 0, NONE, "R12");
    hdice = 1; hv = 0;
    cyc('0, '0, 1, NONE, "R12");
    // R10 level-sensitive sources
    ext_lvl = 1;
    cyc(b(10), '0, 0, NONE, "R10");
    cyc('0, '0, 1, 10, "R10");
    cyc('0, '0, 1, 10, "R10");
    cyc('0, b(10), 0, NONE, "R10");
    cyc('0, '0, 1, NONE, "R10");
    ext_lvl = 0; cext_lvl = 1;
    cyc(b(4), '0, 0, NONE, "R10");
    cyc('0, '0, 1, 4, "R10");
    cyc('0, '0, 1, 4, "R10");
    cyc('0, b(4), 0, NONE, "R10");
    cyc('0, '0, 1, NONE, "R10");
    cext_lvl = 0;
    // R11 decrementer clear-on-delivery
    dec_clr = 0;
    cyc(b(9), '0, 0, NONE, "R11");
    cyc('0, '0, 1, 9, "R11");
    cyc('0, '0, 1, 9, "R11");
    cyc('0, b(9), 0, NONE, "R11");
    cyc('0, '0, 1, NONE, "R11");
    dec_clr = 1;
    cyc(b(9), '0, 0, NONE, "R11");
    cyc('0, '0, 1, 9, "R11");
    cyc('0, '0, 1, NONE, "R11");
    // R12 set wins over clear and over take-clear
    cyc(b(10), b(10), 0, NONE, "R12");
    cyc('0, '0, 1, 10, "R12");
    cyc('0, '0, 1, NONE, "R12");
    cyc(b(10), '0, 0, NONE, "R12");
    cyc(b(10), '0, 1, 10, "R12");
    cyc('0, '0, 1, 10, "R12");
    cyc('0, '0, 1, NONE, "R12");
    @(negedge clk);
    set_s = '0; clr_s = '0; ready = 0;
    while (q_id.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule